// File: doc/BRIEF.md
# Bit-Sliced Integer ALU with Signed Compare

This block is a purely combinational integer arithmetic-logic unit built from one repeated single-bit cell. Each cell holds a full adder, an AND gate, an OR gate and a four-way result selector. The cells are chained through their carries, so the datapath width is set by a parameter. The default width is 32 bits.

A 3-bit operation code selects the function. Its top bit is the operand-negate control, and the same bit drives the carry into bit 0. Subtraction is therefore the sum of the first operand, the complement of the second operand, and one.

The signed compare works without any extra comparator. The top cell computes the sign of the difference and corrects it for overflow. That bit is then routed back to the "less" input of the bottom cell, while every other cell takes a constant zero.

A zero flag makes equality testing possible through subtraction. Overflow and carry-out are reported for add and subtract only.

Top module: `sliced_alu`

## Requirements
- R1: Code 3'b000 gives the bitwise AND of op_a and op_b on result.
- R2: Code 3'b001 gives the bitwise OR of op_a and op_b on result.
- R3: Code 3'b010 gives result = (op_a + op_b) mod 2^WIDTH, with carry_out equal to the carry out of the top bit.
- R4: Code 3'b110 gives result = (op_a - op_b) mod 2^WIDTH, computed as op_a + ~op_b + 1. carry_out is the carry out of the top bit, so it is 1 exactly when op_a >= op_b taken as unsigned values.
- R5: Code 3'b111 sets result bit 0 to 1 when op_a < op_b as two's-complement signed values, and to 0 otherwise. All higher result bits are 0. The comparison stays correct when op_a - op_b overflows.
- R6: zero is 1 exactly when every bit of result is 0, under every operation code.
- R7: For add and subtract, overflow is 1 exactly when the signed result does not fit in WIDTH bits. For every other code, overflow is 0.
- R8: The unused codes 3'b011, 3'b100 and 3'b101 give result 0, zero 1, overflow 0 and carry_out 0.
- R9: carry_out is 0 for the AND, OR and compare codes, whatever the operands are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| op_sel | input | 3 | Operation code; bit 2 negates op_b and drives the bit-0 carry-in |
| result | output | WIDTH | Selected result |
| zero | output | 1 | High when result is all zeros |
| overflow | output | 1 | Signed overflow of add or subtract |
| carry_out | output | 1 | Carry out of the top cell for add or subtract |

## Verification
Several functions can fall in the same evaluation.

The overflow detector and the compare path both read the top cell's carries. The bench therefore drives compares whose difference overflows, for example the most negative value against a positive value, and checks that the set bit follows the true signed order rather than the raw sign.

Overflow, carry-out and the zero flag can also fire together. Adding the most negative value to itself does this: it wraps to zero, and the bench checks that all three flags are set at once. Subtracting equal operands checks that zero rises while overflow stays low.

// File: rtl/alu_pkg.sv
package alu_pkg;

  // Operation codes; bit 2 negates the second operand and feeds carry-in.
  localparam logic [2:0] OP_AND = 3'b000;
  localparam logic [2:0] OP_OR  = 3'b001;
  localparam logic [2:0] OP_ADD = 3'b010;
  localparam logic [2:0] OP_SUB = 3'b110;
  localparam logic [2:0] OP_SLT = 3'b111;

  // Per-cell result selector, taken from the low two code bits.
  typedef enum logic [1:0] {
    SEL_AND  = 2'b00,
    SEL_OR   = 2'b01,
    SEL_SUM  = 2'b10,
    SEL_LESS = 2'b11
  } cell_sel_e;

endpackage

// File: rtl/alu_bit_slice.sv
module alu_bit_slice
  import alu_pkg::*;
(
  input  logic      a_bit,
  input  logic      b_bit,
  input  logic      b_neg,
  input  logic      c_in,
  input  logic      less_in,
  input  cell_sel_e sel,
  input  logic      en,
  output logic      res_bit,
  output logic      sum_bit,
  output logic      c_out
);

  logic b_eff;
  logic half;

  always_comb begin
    b_eff   = b_bit ^ b_neg;
    half    = a_bit ^ b_eff;
    sum_bit = half ^ c_in;
    c_out   = (a_bit & b_eff) | (c_in & half);
  end

  always_comb begin
    res_bit = 1'b0;
    if (en) begin
      unique case (sel)
        SEL_AND:  res_bit = a_bit & b_bit;
        SEL_OR:   res_bit = a_bit | b_bit;
        SEL_SUM:  res_bit = sum_bit;
        SEL_LESS: res_bit = less_in;
        default:  res_bit = 1'b0;
      endcase
    end
  end

endmodule

// File: rtl/alu_zero_detect.sv
module alu_zero_detect #(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] vec,
  output logic             all_clear
);

  always_comb begin
    all_clear = ~(|vec);
  end

endmodule

// File: rtl/sliced_alu.sv
module sliced_alu
  import alu_pkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic [WIDTH-1:0] op_a,
  input  logic [WIDTH-1:0] op_b,
  input  logic [2:0]       op_sel,
  output logic [WIDTH-1:0] result,
  output logic             zero,
  output logic             overflow,
  output logic             carry_out
);

  localparam int MSB = WIDTH - 1;

  logic             code_ok;
  logic             is_arith;
  logic             b_neg;
  cell_sel_e        cell_sel;
  logic [WIDTH:0]   carry;
  logic [WIDTH-1:0] sum_w;
  logic             ovf_raw;
  logic             set_w;

  always_comb begin
    code_ok  = (op_sel == OP_AND) || (op_sel == OP_OR) || (op_sel == OP_ADD) ||
               (op_sel == OP_SUB) || (op_sel == OP_SLT);
    is_arith = (op_sel == OP_ADD) || (op_sel == OP_SUB);
    b_neg    = op_sel[2];
    cell_sel = cell_sel_e'(op_sel[1:0]);
  end

  assign carry[0] = b_neg;

  for (genvar i = 0; i < WIDTH; i++) begin : g_cell
    logic less_w;
    if (i == 0) begin : g_lsb
      assign less_w = set_w;
    end else begin : g_upper
      assign less_w = 1'b0;
    end

    alu_bit_slice u_cell (
      .a_bit   (op_a[i]),
      .b_bit   (op_b[i]),
      .b_neg   (b_neg),
      .c_in    (carry[i]),
      .less_in (less_w),
      .sel     (cell_sel),
      .en      (code_ok),
      .res_bit (result[i]),
      .sum_bit (sum_w[i]),
      .c_out   (carry[i+1])
    );
  end

  // Top-cell overflow and overflow-corrected sign for the compare.
  always_comb begin
    ovf_raw   = carry[MSB] ^ carry[WIDTH];
    set_w     = sum_w[MSB] ^ ovf_raw;
    overflow  = is_arith & ovf_raw;
    carry_out = is_arith & carry[WIDTH];
  end

  alu_zero_detect #(.WIDTH(WIDTH)) u_zero (
    .vec       (result),
    .all_clear (zero)
  );

  always_comb begin
    if (op_sel == OP_ADD) begin
      // R3
      add_sum_chk: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}))
        else $error("add sum mismatch");
    end
    if (op_sel == OP_SUB) begin
      // R4
      sub_diff_chk: assert (result == (op_a - op_b))
        else $error("subtract mismatch");
    end
    if (op_sel == OP_SLT) begin
      // R5
      slt_upper_chk: assert (result[WIDTH-1:1] == '0)
        else $error("compare upper bits set");
    end
    if (!is_arith) begin
      // R7
      no_overflow_chk: assert (!overflow && !carry_out)
        else $error("flag set outside add/sub");
    end
    if (!code_ok) begin
      // R8
      unused_code_chk: assert (result == '0 && zero)
        else $error("unused code gave data");
    end
  end

endmodule

// File: tb/sliced_alu_tb.sv
module sliced_alu_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int W = 32;

  logic         clk;
  logic         rst_n;
  logic [W-1:0] op_a;
  logic [W-1:0] op_b;
  logic [2:0]   op_sel;
  logic [W-1:0] result;
  logic         zero;
  logic         overflow;
  logic         carry_out;

  int checks;
  int errors;

  sliced_alu #(.WIDTH(W)) dut_i (
    .op_a      (op_a),
    .op_b      (op_b),
    .op_sel    (op_sel),
    .result    (result),
    .zero      (zero),
    .overflow  (overflow),
    .carry_out (carry_out)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Drive on the falling edge, then compare a quarter period later.
  task automatic run_case(input string req, input logic [W-1:0] a,
                          input logic [W-1:0] b, input logic [2:0] op);
    logic [W:0]   wide;
    logic [W-1:0] e_res;
    logic         e_ovf;
    logic         e_cout;
    @(negedge clk);
    op_a = a; op_b = b; op_sel = op;
    e_res = '0; e_ovf = 1'b0; e_cout = 1'b0;
    case (op)
      3'b000: e_res = a & b;
      3'b001: e_res = a | b;
      3'b010: begin
        wide   = {1'b0, a} + {1'b0, b};
        e_res  = wide[W-1:0];
        e_cout = wide[W];
        e_ovf  = (a[W-1] == b[W-1]) && (e_res[W-1] != a[W-1]);
      end
      3'b110: begin
        wide   = {1'b0, a} + {1'b0, ~b} + 1;
        e_res  = wide[W-1:0];
        e_cout = wide[W];
        e_ovf  = (a[W-1] != b[W-1]) && (e_res[W-1] != a[W-1]);
      end
      3'b111: e_res = ($signed(a) < $signed(b)) ? 1 : 0;
      default: e_res = '0;
    endcase
    #(CLK_PERIOD/4);
    check(req, "result", result, e_res);
    check("R6", "zero", {31'b0, zero}, {31'b0, (e_res == '0)});
    check((op == 3'b010 || op == 3'b110) ? "R7" : "R7/R8", "overflow",
          {31'b0, overflow}, {31'b0, e_ovf});
    check((op == 3'b010) ? "R3" : (op == 3'b110) ? "R4" : "R9", "carry_out",
          {31'b0, carry_out}, {31'b0, e_cout});
  endtask

  task automatic t_idle;
    // Reset-state inputs: all zero is AND of zeros.
    run_case("R1", '0, '0, 3'b000);
  endtask

  task automatic t_logic;
    run_case("R1", 32'hF0F0_1234, 32'h0FF0_FFFF, 3'b000);
    run_case("R1", 32'hAAAA_5555, 32'h5555_AAAA, 3'b000);
    run_case("R2", 32'h0000_00F0, 32'h0F00_000F, 3'b001);
    run_case("R2", 32'h0, 32'h0, 3'b001);
  endtask

  task automatic t_add;
    run_case("R3", 32'd1234, 32'd5678, 3'b010);
    run_case("R3", 32'hFFFF_FFFF, 32'h1, 3'b010);
    run_case("R3", 32'h7FFF_FFFF, 32'h1, 3'b010);
    run_case("R3", 32'h8000_0000, 32'h8000_0000, 3'b010);
  endtask

  task automatic t_sub;
    run_case("R4", 32'd100, 32'd58, 3'b110);
    run_case("R4", 32'd5, 32'd9, 3'b110);
    run_case("R4", 32'hDEAD_BEEF, 32'hDEAD_BEEF, 3'b110);
    run_case("R4", 32'h8000_0000, 32'h1, 3'b110);
    run_case("R4", 32'h7FFF_FFFF, 32'hFFFF_FFFF, 3'b110);
  endtask

  task automatic t_slt;
    run_case("R5", 32'd3, 32'd7, 3'b111);
    run_case("R5", 32'd7, 32'd3, 3'b111);
    run_case("R5", 32'hFFFF_FFFF, 32'h1, 3'b111);
    run_case("R5", 32'h5, 32'h5, 3'b111);
    run_case("R5", 32'h8000_0000, 32'h7FFF_FFFF, 3'b111);
    run_case("R5", 32'h7FFF_FFFF, 32'h8000_0000, 3'b111);
  endtask

  task automatic t_unused;
    run_case("R8", 32'hFFFF_FFFF, 32'hFFFF_FFFF, 3'b011);
    run_case("R8", 32'h8000_0000, 32'h8000_0000, 3'b100);
    run_case("R8", 32'h1234_5678, 32'hFFFF_0000, 3'b101);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    op_a = '0; op_b = '0; op_sel = 3'b000;
    rst_n = 1'b0;
    repeat (2) @(posedge clk);
    rst_n = 1'b1;
    t_idle();
    t_logic();
    t_add();
    t_sub();
    t_slt();
    t_unused();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule